// File: doc/BRIEF.md
# Passive Two-Lane SPI Bus Monitor

This block listens to an SPI bus owned by other devices and turns the traffic on both data lines into parallel words. It takes the monitored serial clock, the active-low chip select and the two data lines as plain inputs. It re-times them into a faster system clock and shifts the controller-to-peripheral line and the peripheral-to-controller line into two separate receivers at the same time. The block has no outputs toward the bus, so it cannot disturb the traffic it watches.

Each receiver reports a finished word with a one-cycle valid strobe. Its lane is given by the strobe's index: index 0 carries the controller-to-peripheral line and index 1 the peripheral-to-controller line. Separate one-cycle pulses mark where a frame opens and where it closes. A frame that closes on a partial word raises a per-lane error pulse and emits no word for that partial word. Extra or missing clock edges on the bus therefore show up as error pulses and do not shift later words out of alignment.

The block is meant to sit in front of a logger. Storage, time stamping and transfer to a host are left to the logic that follows it.

Top module: `spi_snoop`

## Requirements
- R1: Lane 0 deserializes `mosi_i` and lane 1 deserializes `miso_i` from the same clock and select. When both lanes see the same number of bits, they assert `valid_o` in the same cycle.
- R2: Bits are taken on the rising synchronized `sck_i` edge (clock mode 0 by default) while `nss_i` is low. The first bit received lands in the most significant bit of the word.
- R3: With `len16_i` = 0 a word is 8 bits, placed in `data_o[lane][7:0]` with bits [15:8] zero. With `len16_i` = 1 a word is 16 bits. The length is latched when the frame opens, and changing `len16_i` during a frame has no effect on that frame.
- R4: Each completed word produces exactly one `valid_o[lane]` pulse lasting one system clock. `data_o[lane]` holds that word while the pulse is high.
- R5: If `nss_i` rises while a lane holds between 1 and word-length minus 1 bits, that lane pulses `err_o[lane]` for one cycle and emits no word for those bits. A frame that closes on a word boundary raises no error.
- R6: The bit count is cleared whenever `nss_i` falls, so a frame that follows a malformed one is decoded from its first bit.
- R7: Clock edges seen while `nss_i` is high produce no word, no error and no frame pulse.
- R8: `frame_start_o` pulses once when the synchronized `nss_i` falls, and `frame_end_o` pulses once when it rises. An `err_o` pulse occurs in the same cycle as `frame_end_o`.
- R9: While `rst_n` is low, all outputs are zero.
- R10: Words arrive with no gaps and no losses at a bus clock of one eighth of the system clock, through frames of 40 and 48 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bus clock |
| rst_n | input | 1 | Active-low reset |
| len16_i | input | 1 | Word length select: 0 = 8 bits, 1 = 16 bits |
| sck_i | input | 1 | Monitored bus clock (asynchronous) |
| nss_i | input | 1 | Monitored chip select, active low (asynchronous) |
| mosi_i | input | 1 | Monitored controller-to-peripheral data |
| miso_i | input | 1 | Monitored peripheral-to-controller data |
| valid_o | output | 2 | Per-lane word-complete strobe |
| data_o | output | 2x16 | Per-lane received word |
| err_o | output | 2 | Per-lane partial-word error strobe |
| frame_start_o | output | 1 | Frame-open pulse |
| frame_end_o | output | 1 | Frame-close pulse |

## Verification
Random frames mix both word lengths, independent random data on each lane, and bit counts that are either whole multiples of the word length or leave a remainder. This separates correct word splitting and bit order from errors caused by miscounting. Directed frames cover several cases: clocking while the select is idle, a short malformed frame followed by a clean one (which exposes a count that is not cleared), a length change in the middle of a frame, and long 40- and 48-byte bursts that would reveal dropped or merged words.

// File: rtl/spi_snoop_pkg.sv
package spi_snoop_pkg;

    localparam int unsigned SNOOP_LANES = 2;

    typedef enum logic {
        LANE_PICO = 1'b0,
        LANE_POCI = 1'b1
    } snoop_lane_e;

    function automatic logic sample_on_rise(input int unsigned mode);
        return ((mode >> 1) & 1) == (mode & 1);
    endfunction

endpackage

// File: rtl/spi_snoop_sync.sv
module spi_snoop_sync #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;
    logic [STAGES-1:0][WIDTH-1:0] stage_d;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RESET_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_snoop_frame.sv
module spi_snoop_frame #(
    parameter int unsigned SPI_MODE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic nss_s,
    input  logic len16_i,
    output logic sample_stb,
    output logic start_stb,
    output logic end_stb,
    output logic len16_q,
    output logic frame_start_o,
    output logic frame_end_o
);

    localparam logic IDLE_SCK = logic'((SPI_MODE >> 1) & 1);
    localparam logic RISE_EDGE = spi_snoop_pkg::sample_on_rise(SPI_MODE);

    typedef struct packed {
        logic sck_prev;
        logic nss_prev;
        logic len16;
        logic fs;
        logic fe;
    } frame_state_t;

    frame_state_t state_d, state_q;
    logic sck_rise, sck_fall;

    always_comb begin
        state_d    = state_q;
        sck_rise   = sck_s & ~state_q.sck_prev;
        sck_fall   = ~sck_s & state_q.sck_prev;
        start_stb  = state_q.nss_prev & ~nss_s;
        end_stb    = ~state_q.nss_prev & nss_s;
        sample_stb = ~nss_s & (RISE_EDGE ? sck_rise : sck_fall);

        state_d.sck_prev = sck_s;
        state_d.nss_prev = nss_s;
        state_d.fs       = start_stb;
        state_d.fe       = end_stb;
        if (start_stb) begin
            state_d.len16 = len16_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sck_prev: IDLE_SCK, nss_prev: 1'b1, len16: 1'b0, fs: 1'b0, fe: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign len16_q       = state_q.len16;
    assign frame_start_o = state_q.fs;
    assign frame_end_o   = state_q.fe;

endmodule

// File: rtl/spi_snoop_lane.sv
module spi_snoop_lane #(
    parameter int unsigned SHORT_W = 8,
    parameter int unsigned LONG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_s,
    input  logic              sample_stb,
    input  logic              start_stb,
    input  logic              end_stb,
    input  logic              len16,
    output logic              valid_o,
    output logic [LONG_W-1:0] data_o,
    output logic              err_o
);

    localparam int unsigned CNT_W = $clog2(LONG_W + 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);

    typedef struct packed {
        logic [LONG_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [LONG_W-1:0] data;
        logic              err;
    } lane_state_t;

    lane_state_t state_d, state_q;
    logic [LONG_W-1:0] shifted;
    logic [CNT_W-1:0]  last_idx;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        state_d.err   = 1'b0;
        shifted       = {state_q.shreg[LONG_W-2:0], bit_s};
        last_idx      = len16 ? LAST_LONG : LAST_SHORT;

        if (start_stb) begin
            state_d.cnt   = '0;
            state_d.shreg = '0;
        end else if (end_stb) begin
            state_d.err   = (state_q.cnt != '0);
            state_d.cnt   = '0;
            state_d.shreg = '0;
        end else if (sample_stb) begin
            if (state_q.cnt == last_idx) begin
                state_d.valid = 1'b1;
                state_d.data  = shifted;
                state_d.cnt   = '0;
                state_d.shreg = '0;
            end else begin
                state_d.shreg = shifted;
                state_d.cnt   = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign valid_o = state_q.valid;
    assign data_o  = state_q.data;
    assign err_o   = state_q.err;

endmodule

// File: rtl/spi_snoop.sv
module spi_snoop #(
    parameter int unsigned SPI_MODE    = 0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SHORT_W     = 8,
    parameter int unsigned LONG_W      = 16
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              len16_i,
    input  logic                                              sck_i,
    input  logic                                              nss_i,
    input  logic                                              mosi_i,
    input  logic                                              miso_i,
    output logic [spi_snoop_pkg::SNOOP_LANES-1:0]             valid_o,
    output logic [spi_snoop_pkg::SNOOP_LANES-1:0][LONG_W-1:0] data_o,
    output logic [spi_snoop_pkg::SNOOP_LANES-1:0]             err_o,
    output logic                                              frame_start_o,
    output logic                                              frame_end_o
);

    import spi_snoop_pkg::*;

    localparam logic IDLE_SCK = logic'((SPI_MODE >> 1) & 1);
    localparam int unsigned SYNC_W = 2 + SNOOP_LANES;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic sck_s, nss_s;
    logic [SNOOP_LANES-1:0] lane_bit;
    logic sample_stb, start_stb, end_stb, len16_q;

    assign raw_in = {miso_i, mosi_i, nss_i, sck_i};

    spi_snoop_sync #(
        .WIDTH    (SYNC_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL({{SNOOP_LANES{1'b0}}, 1'b1, IDLE_SCK})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (sync_out)
    );

    assign sck_s    = sync_out[0];
    assign nss_s    = sync_out[1];
    assign lane_bit = sync_out[SYNC_W-1:2];

    spi_snoop_frame #(
        .SPI_MODE(SPI_MODE)
    ) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_s        (sck_s),
        .nss_s        (nss_s),
        .len16_i      (len16_i),
        .sample_stb   (sample_stb),
        .start_stb    (start_stb),
        .end_stb      (end_stb),
        .len16_q      (len16_q),
        .frame_start_o(frame_start_o),
        .frame_end_o  (frame_end_o)
    );

    for (genvar g = 0; g < SNOOP_LANES; g++) begin : g_lane
        spi_snoop_lane #(
            .SHORT_W(SHORT_W),
            .LONG_W (LONG_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .bit_s     (lane_bit[g]),
            .sample_stb(sample_stb),
            .start_stb (start_stb),
            .end_stb   (end_stb),
            .len16     (len16_q),
            .valid_o   (valid_o[g]),
            .data_o    (data_o[g]),
            .err_o     (err_o[g])
        );
    end

endmodule

// File: rtl/spi_snoop_chk.sv
module spi_snoop_chk #(
    parameter int unsigned LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] valid_o,
    input logic [LANES-1:0] err_o,
    input logic             frame_start_o,
    input logic             frame_end_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R4
        valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o[g] |=> !valid_o[g]);
        // R5
        err_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(err_o[g] && valid_o[g]));
        // R8
        err_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[g] |-> frame_end_o);
    end

    // R8
    open_close_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start_o && frame_end_o));

    // R8
    close_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> !frame_end_o);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (valid_o == '0 && err_o == '0 && !frame_start_o && !frame_end_o));

endmodule

bind spi_snoop spi_snoop_chk #(
    .LANES(spi_snoop_pkg::SNOOP_LANES)
) u_spi_snoop_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_o      (valid_o),
    .err_o        (err_o),
    .frame_start_o(frame_start_o),
    .frame_end_o  (frame_end_o)
);

// File: tb/test_spi_snoop.sv
module test_spi_snoop;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int MAXB       = 384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic len16 = 1'b0;
    logic sck = 1'b0;
    logic nss = 1'b1;
    logic mosi = 1'b0;
    logic miso = 1'b0;
    logic [1:0] valid, err;
    logic [1:0][15:0] data;
    logic fs, fe;

    int checks = 0;
    int errors = 0;
    logic [15:0] q0[$];
    logic [15:0] q1[$];
    int n_err0, n_err1, n_fs, n_fe, n_split;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_snoop i_spi_snoop (
        .clk          (clk),
        .rst_n        (rst_n),
        .len16_i      (len16),
        .sck_i        (sck),
        .nss_i        (nss),
        .mosi_i       (mosi),
        .miso_i       (miso),
        .valid_o      (valid),
        .data_o       (data),
        .err_o        (err),
        .frame_start_o(fs),
        .frame_end_o  (fe)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid[0]) q0.push_back(data[0]);
            if (valid[1]) q1.push_back(data[1]);
            if (valid[0] != valid[1]) n_split++;
            if (err[0]) n_err0++;
            if (err[1]) n_err1++;
            if (fs) n_fs++;
            if (fe) n_fe++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        q0.delete();
        q1.delete();
        n_err0 = 0; n_err1 = 0; n_fs = 0; n_fe = 0; n_split = 0;
    endtask

    function automatic logic [15:0] exp_word(input logic [MAXB-1:0] v, input int nbits,
                                             input int w, input int k);
        logic [MAXB-1:0] t;
        t = v >> (nbits - w * (k + 1));
        return (w == 16) ? t[15:0] : {8'h00, t[7:0]};
    endfunction

    function automatic logic [MAXB-1:0] rand_vec();
        logic [MAXB-1:0] v;
        for (int i = 0; i < MAXB / 32; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    task automatic run_frame(input logic [MAXB-1:0] vm, input logic [MAXB-1:0] vs,
                             input int nbits, input bit l16, input int flip_at);
        len16 = l16;
        nss = 1'b0;
        repeat (HALF_SCK) @(negedge clk);
        for (int b = nbits - 1; b >= 0; b--) begin
            mosi = vm[b];
            miso = vs[b];
            if (nbits - 1 - b == flip_at) len16 = ~l16;
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b1;
            repeat (HALF_SCK) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF_SCK) @(negedge clk);
        nss = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic verify_frame(input logic [MAXB-1:0] vm, input logic [MAXB-1:0] vs,
                                input int nbits, input bit l16, input string req);
        int w, nw, part;
        w = l16 ? 16 : 8;
        nw = nbits / w;
        part = (nbits % w != 0) ? 1 : 0;
        check(q0.size() == nw, {req, " R4"}, "lane0 word count", q0.size(), nw);
        check(q1.size() == nw, {req, " R1"}, "lane1 word count", q1.size(), nw);
        for (int k = 0; k < nw && k < q0.size() && k < q1.size(); k++) begin
            check(q0[k] == exp_word(vm, nbits, w, k), {req, " R2"}, "lane0 data",
                  q0[k], exp_word(vm, nbits, w, k));
            check(q1[k] == exp_word(vs, nbits, w, k), {req, " R1"}, "lane1 data",
                  q1[k], exp_word(vs, nbits, w, k));
        end
        check(n_err0 == part, {req, " R5"}, "lane0 error pulses", n_err0, part);
        check(n_err1 == part, {req, " R5"}, "lane1 error pulses", n_err1, part);
        check(n_fs == 1 && n_fe == 1, {req, " R8"}, "frame pulses", n_fs * 16 + n_fe, 17);
        check(n_split == 0, {req, " R1"}, "lanes valid apart", n_split, 0);
    endtask

    task automatic frame_and_check(input logic [MAXB-1:0] vm, input logic [MAXB-1:0] vs,
                                   input int nbits, input bit l16, input string req);
        clear_mon();
        run_frame(vm, vs, nbits, l16, -1);
        verify_frame(vm, vs, nbits, l16, req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [MAXB-1:0] vm, vs;
        void'($urandom(32'h5EED1234));
        clear_mon();
        repeat (5) @(negedge clk);
        // R9: outputs quiet during reset
        check(valid == 2'b00 && err == 2'b00 && !fs && !fe, "R9", "outputs in reset",
              {valid, err, fs, fe}, 0);
        check(data == '0, "R9", "data in reset", data, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2/R1: directed 8-bit frame with known bytes
        vm = '0; vs = '0;
        vm[15:0] = 16'hA53C; vs[15:0] = 16'h0FF1;
        frame_and_check(vm, vs, 16, 1'b0, "R3 len8");
        // R3: same bits as one 16-bit word
        frame_and_check(vm, vs, 16, 1'b1, "R3 len16");

        // R7: clock toggling while select idle
        clear_mon();
        for (int i = 0; i < 20; i++) begin
            mosi = i[0]; miso = ~i[0];
            repeat (HALF_SCK) @(negedge clk); sck = 1'b1;
            repeat (HALF_SCK) @(negedge clk); sck = 1'b0;
        end
        repeat (12) @(negedge clk);
        check(q0.size() + q1.size() == 0, "R7", "words while idle", q0.size() + q1.size(), 0);
        check(n_err0 + n_err1 + n_fs + n_fe == 0, "R7", "pulses while idle",
              n_err0 + n_err1 + n_fs + n_fe, 0);
        vm[15:0] = 16'h81C7; vs[15:0] = 16'h7E18;
        frame_and_check(vm, vs, 16, 1'b0, "R7 after idle");

        // R5/R6: malformed short frame, then clean frame must be aligned
        vm[4:0] = 5'h15; vs[4:0] = 5'h0A;
        frame_and_check(vm, vs, 5, 1'b0, "R5 partial");
        vm[15:0] = 16'hC3E1; vs[15:0] = 16'h5A96;
        frame_and_check(vm, vs, 16, 1'b0, "R6 realign");
        vm[20:0] = 21'h1ABCDE; vs[20:0] = 21'h0F0F0F;
        frame_and_check(vm, vs, 21, 1'b1, "R5 partial16");
        frame_and_check(vm, vs, 16, 1'b1, "R6 realign16");

        // R3: length change mid-frame has no effect
        vm[23:0] = 24'h123456; vs[23:0] = 24'hFEDCBA;
        clear_mon();
        run_frame(vm, vs, 24, 1'b0, 3);
        verify_frame(vm, vs, 24, 1'b0, "R3 midflip");
        len16 = 1'b0;

        // R10: long bursts
        vm = rand_vec(); vs = rand_vec();
        frame_and_check(vm, vs, 384, 1'b0, "R10 48B");
        vm = rand_vec(); vs = rand_vec();
        frame_and_check(vm, vs, 320, 1'b1, "R10 40B");

        // random frames, whole words or with a remainder
        for (int f = 0; f < 30; f++) begin
            int w, nb;
            bit l16;
            l16 = $urandom_range(1, 0);
            w = l16 ? 16 : 8;
            nb = w * $urandom_range(4, 1);
            if ($urandom_range(3, 0) == 0) nb = nb + $urandom_range(w - 1, 1);
            vm = rand_vec(); vs = rand_vec();
            frame_and_check(vm, vs, nb, l16, "R2 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule